// File: doc/BRIEF.md
# Dual-Bus Transfer Retry Controller

This block takes one bus transfer request from a descriptor sequencer and makes attempts on a pair of redundant buses until one attempt succeeds or its retry allowance runs out. A request carries a packed options word. Three fields of that word matter to the block: the bus for the first attempt, a retry policy and a retry count. Before each attempt the block chooses a bus from the policy and the attempt number. It then pulses a start strobe toward the transceiver side and waits for a result strobe that carries a success flag. Word encoding, response timeout measurement and descriptor fetching all happen elsewhere. A timed-out response simply comes back as a failed result.

When the transfer concludes, the block raises a one-cycle done strobe. With it come the final outcome, the bus of the last attempt and the total number of attempts. Only one request is handled at a time. A request presented while the block is busy is dropped.

Top module: `dual_bus_retry`

## Requirements
- R1: After reset, busy_o, att_start_o and done_o are all low.
- R2: A request is taken only in a cycle where busy_o is low. A request raised while busy_o is high, including in the same cycle as the concluding result, is ignored and does not change the running transfer. A request in the same cycle as done_o is accepted.
- R3: Options bit 0 selects the starting bus (0 = bus A, driven as att_bus_o = 0; 1 = bus B). Bits 22:20 hold the retry count and bits 24:23 the retry policy. All other bits have no effect. The first attempt always goes to the starting bus. It starts (att_start_o high) in the cycle after acceptance.
- R4: A retry count of 0 gives exactly one attempt. Counts of 7 are clamped to 6, which gives at most 7 attempts.
- R5: Policy 0 puts every attempt on the starting bus. The unused policy value 3 behaves the same way.
- R6: Policy 1 alternates buses. Attempt k (k = 0 first) uses the starting bus when k is even and the other bus when k is odd.
- R7: Policy 2 with n retries puts attempts 0 through ceil(n/2) on the starting bus and every later attempt on the other bus.
- R8: The first result with att_ok_i high ends the transfer, and done_ok_o is then 1. No further attempt is started.
- R9: If every attempt fails, the transfer ends after n+1 attempts with done_ok_o = 0.
- R10: done_o is high for exactly one cycle, the cycle after the concluding result. In that cycle done_bus_o is the bus of the last attempt and done_attempts_o is the attempt count, counted from 1.
- R11: att_start_o is a one-cycle pulse per attempt. After a failed result that does not conclude the transfer, the next attempt starts in the following cycle. A result strobe is ignored whenever no attempt is outstanding, both while idle and in the start cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Transfer request strobe |
| req_opts_i | input | OPT_W | Options word with start bus, retry count and retry policy |
| busy_o | output | 1 | A transfer is in progress |
| att_start_o | output | 1 | Start of one bus attempt |
| att_bus_o | output | 1 | Bus for the current attempt (0 = A, 1 = B) |
| att_done_i | input | 1 | Result strobe for the outstanding attempt |
| att_ok_i | input | 1 | Attempt succeeded, valid with att_done_i |
| done_o | output | 1 | Transfer concluded |
| done_ok_o | output | 1 | Final outcome, 1 = success |
| done_bus_o | output | 1 | Bus used by the last attempt |
| done_attempts_o | output | ATT_W | Number of attempts made |

## Verification
Two events can land in the same cycle: the block concluding a transfer on its final result, and the sequencer raising a new request. The bench drives a request in the very cycle of the concluding result. It then checks that done_o appears with busy_o low and no new attempt. Next it drives a request during the done_o cycle and checks that the request is accepted, with busy_o and att_start_o high in the cycle after. Random transfers also inject stray requests while attempts are outstanding, and the bench confirms that the attempt sequence and the reported count follow the original options.

// File: rtl/dual_bus_retry_pkg.sv
package dual_bus_retry_pkg;
  typedef enum logic [1:0] {
    RM_SAME  = 2'd0,
    RM_ALT   = 2'd1,
    RM_SPLIT = 2'd2,
    RM_RSVD  = 2'd3
  } retry_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_WAIT   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/rtc_opt_decode.sv
module rtc_opt_decode
  import dual_bus_retry_pkg::*;
#(
  parameter int OPT_W     = 32,
  parameter int BUS_BIT   = 0,
  parameter int RCNT_LSB  = 20,
  parameter int RCNT_W    = 3,
  parameter int MODE_LSB  = 23,
  parameter int MAX_RETRY = 6,
  parameter int ATT_W     = 3
) (
  input  logic [OPT_W-1:0] opts_i,
  output logic             start_bus_o,
  output retry_mode_e      mode_o,
  output logic [ATT_W-1:0] nretry_o
);
  logic [RCNT_W-1:0] raw_cnt;
  logic [31:0]       raw_ext;

  assign start_bus_o = opts_i[BUS_BIT];
  assign mode_o      = retry_mode_e'(opts_i[MODE_LSB +: 2]);
  assign raw_cnt     = opts_i[RCNT_LSB +: RCNT_W];
  assign raw_ext     = 32'(raw_cnt);

  // clamp oversize counts to the supported maximum
  always_comb begin
    if (raw_ext > 32'(MAX_RETRY)) nretry_o = ATT_W'(MAX_RETRY);
    else                          nretry_o = ATT_W'(raw_ext);
  end
endmodule

// File: rtl/rtc_bus_pick.sv
module rtc_bus_pick
  import dual_bus_retry_pkg::*;
#(
  parameter int ATT_W         = 3,
  parameter bit RSVD_AS_SAME  = 1'b1
) (
  input  logic             start_bus_i,
  input  retry_mode_e      mode_i,
  input  logic [ATT_W-1:0] nretry_i,
  input  logic [ATT_W-1:0] idx_i,
  output logic             bus_o
);
  logic [ATT_W:0] half;
  logic           split_bus;
  logic           rsvd_bus;

  // retries on the original bus in split mode: ceil(n/2)
  assign half      = ({1'b0, nretry_i} + 1'b1) >> 1;
  assign split_bus = ({1'b0, idx_i} <= half) ? start_bus_i : ~start_bus_i;

  generate
    if (RSVD_AS_SAME) begin : g_rsvd_same
      assign rsvd_bus = start_bus_i;
    end else begin : g_rsvd_alt
      assign rsvd_bus = start_bus_i ^ idx_i[0];
    end
  endgenerate

  always_comb begin
    unique case (mode_i)
      RM_SAME:  bus_o = start_bus_i;
      RM_ALT:   bus_o = start_bus_i ^ idx_i[0];
      RM_SPLIT: bus_o = split_bus;
      default:  bus_o = rsvd_bus;
    endcase
  end
endmodule

// File: rtl/rtc_attempt_fsm.sv
module rtc_attempt_fsm
  import dual_bus_retry_pkg::*;
#(
  parameter int ATT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             cfg_bus_i,
  input  retry_mode_e      cfg_mode_i,
  input  logic [ATT_W-1:0] cfg_nretry_i,
  input  logic             att_done_i,
  input  logic             att_ok_i,
  input  logic             cur_bus_i,
  output logic             lat_bus_o,
  output retry_mode_e      lat_mode_o,
  output logic [ATT_W-1:0] lat_nretry_o,
  output logic [ATT_W-1:0] idx_o,
  output logic             busy_o,
  output logic             att_start_o,
  output logic             done_o,
  output logic             done_ok_o,
  output logic             done_bus_o,
  output logic [ATT_W-1:0] done_attempts_o
);
  seq_state_e       state_q;
  logic [ATT_W-1:0] idx_q;
  logic             is_last;
  logic             finish;

  assign is_last  = (idx_q == lat_nretry_o);
  assign finish   = (state_q == ST_WAIT) && att_done_i && (att_ok_i || is_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      idx_q        <= '0;
      lat_bus_o    <= 1'b0;
      lat_mode_o   <= RM_SAME;
      lat_nretry_o <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            state_q      <= ST_LAUNCH;
            idx_q        <= '0;
            lat_bus_o    <= cfg_bus_i;
            lat_mode_o   <= cfg_mode_i;
            lat_nretry_o <= cfg_nretry_i;
          end
        end
        ST_LAUNCH: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (finish) begin
            state_q <= ST_IDLE;
          end else if (att_done_i) begin
            state_q <= ST_LAUNCH;
            idx_q   <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o          <= 1'b0;
      done_ok_o       <= 1'b0;
      done_bus_o      <= 1'b0;
      done_attempts_o <= '0;
    end else begin
      done_o <= finish;
      if (finish) begin
        done_ok_o       <= att_ok_i;
        done_bus_o      <= cur_bus_i;
        done_attempts_o <= idx_q + 1'b1;
      end
    end
  end

  assign idx_o       = idx_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign att_start_o = (state_q == ST_LAUNCH);
endmodule

// File: rtl/dual_bus_retry.sv
module dual_bus_retry
  import dual_bus_retry_pkg::*;
#(
  parameter int OPT_W     = 32,
  parameter int BUS_BIT   = 0,
  parameter int RCNT_LSB  = 20,
  parameter int RCNT_W    = 3,
  parameter int MODE_LSB  = 23,
  parameter int MAX_RETRY = 6,
  localparam int ATT_W    = $clog2(MAX_RETRY + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [OPT_W-1:0] req_opts_i,
  output logic             busy_o,
  output logic             att_start_o,
  output logic             att_bus_o,
  input  logic             att_done_i,
  input  logic             att_ok_i,
  output logic             done_o,
  output logic             done_ok_o,
  output logic             done_bus_o,
  output logic [ATT_W-1:0] done_attempts_o
);
  logic             dec_bus;
  retry_mode_e      dec_mode;
  logic [ATT_W-1:0] dec_nretry;
  logic             lat_bus;
  retry_mode_e      lat_mode;
  logic [ATT_W-1:0] lat_nretry;
  logic [ATT_W-1:0] idx;

  rtc_opt_decode #(
    .OPT_W(OPT_W), .BUS_BIT(BUS_BIT), .RCNT_LSB(RCNT_LSB), .RCNT_W(RCNT_W),
    .MODE_LSB(MODE_LSB), .MAX_RETRY(MAX_RETRY), .ATT_W(ATT_W)
  ) u_dec (
    .opts_i(req_opts_i), .start_bus_o(dec_bus), .mode_o(dec_mode), .nretry_o(dec_nretry)
  );

  rtc_bus_pick #(.ATT_W(ATT_W), .RSVD_AS_SAME(1'b1)) u_pick (
    .start_bus_i(lat_bus), .mode_i(lat_mode), .nretry_i(lat_nretry),
    .idx_i(idx), .bus_o(att_bus_o)
  );

  rtc_attempt_fsm #(.ATT_W(ATT_W)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
    .cfg_bus_i(dec_bus), .cfg_mode_i(dec_mode), .cfg_nretry_i(dec_nretry),
    .att_done_i(att_done_i), .att_ok_i(att_ok_i), .cur_bus_i(att_bus_o),
    .lat_bus_o(lat_bus), .lat_mode_o(lat_mode), .lat_nretry_o(lat_nretry),
    .idx_o(idx), .busy_o(busy_o), .att_start_o(att_start_o),
    .done_o(done_o), .done_ok_o(done_ok_o), .done_bus_o(done_bus_o),
    .done_attempts_o(done_attempts_o)
  );
endmodule

// File: rtl/dual_bus_retry_checker.sv
module dual_bus_retry_checker #(
  parameter int MAX_RETRY = 6,
  parameter int ATT_W     = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             busy_o,
  input logic             att_start_o,
  input logic             att_done_i,
  input logic             att_ok_i,
  input logic             done_o,
  input logic             done_ok_o,
  input logic [ATT_W-1:0] done_attempts_o
);
  assert_start_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    att_start_o |=> !att_start_o);

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_accept_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_valid_i) |=> (busy_o && att_start_o));

  assert_attempt_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (done_attempts_o >= ATT_W'(1) && done_attempts_o <= ATT_W'(MAX_RETRY + 1)));

  // busy and not launching means an attempt is outstanding
  assert_stop_on_ok_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !att_start_o && att_done_i && att_ok_i) |=> (done_o && done_ok_o));
endmodule

bind dual_bus_retry dual_bus_retry_checker #(.MAX_RETRY(MAX_RETRY), .ATT_W(ATT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .busy_o(busy_o),
  .att_start_o(att_start_o), .att_done_i(att_done_i), .att_ok_i(att_ok_i),
  .done_o(done_o), .done_ok_o(done_ok_o), .done_attempts_o(done_attempts_o)
);

// File: tb/dual_bus_retry_tb_top.sv
`timescale 1ns/1ps
module dual_bus_retry_tb_top;
  localparam int ATT_W = 3;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             req_valid_i = 1'b0;
  logic [31:0]      req_opts_i = '0;
  logic             busy_o, att_start_o, att_bus_o;
  logic             att_done_i = 1'b0, att_ok_i = 1'b0;
  logic             done_o, done_ok_o, done_bus_o;
  logic [ATT_W-1:0] done_attempts_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #2.5 clk_i = ~clk_i;

  dual_bus_retry dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_opts_i(req_opts_i),
    .busy_o(busy_o), .att_start_o(att_start_o), .att_bus_o(att_bus_o),
    .att_done_i(att_done_i), .att_ok_i(att_ok_i), .done_o(done_o),
    .done_ok_o(done_ok_o), .done_bus_o(done_bus_o), .done_attempts_o(done_attempts_o)
  );

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int clamp_n(input int cnt);
    return (cnt > 6) ? 6 : cnt;
  endfunction

  function automatic bit exp_bus(input bit sb, input int md, input int n, input int k);
    if (md == 1) return sb ^ k[0];
    if (md == 2) return (k <= (n + 1) / 2) ? sb : ~sb;
    return sb;
  endfunction

  function automatic string mode_tag(input int md);
    if (md == 1) return "R6 alternate bus";
    if (md == 2) return "R7 split bus";
    return "R5 same bus";
  endfunction

  function automatic logic [31:0] make_opts(input bit sb, input int md, input int cnt);
    logic [31:0] o;
    o = $urandom();
    o[0] = sb;
    o[22:20] = cnt[2:0];
    o[24:23] = md[1:0];
    return o;
  endfunction

  // fmask bit k = 1 means attempt k fails
  task automatic run_case(input bit sb, input int md, input int cnt, input logic [7:0] fmask,
                          input int lat, input bit poke);
    int n;
    bit ok;
    n = clamp_n(cnt);
    @(negedge clk_i);
    req_valid_i = 1'b1;
    req_opts_i  = make_opts(sb, md, cnt);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    for (int k = 0; k <= n; k++) begin
      check(att_start_o == 1'b1, "R11 attempt start", att_start_o, 1);
      check(att_bus_o == exp_bus(sb, md, n, k), (k == 0) ? "R3 start bus" : mode_tag(md),
            att_bus_o, exp_bus(sb, md, n, k));
      for (int w = 0; w < lat; w++) begin
        @(negedge clk_i);
        if (w == 0) check(att_start_o == 1'b0 && busy_o, "R11 start one cycle", att_start_o, 0);
        req_valid_i = poke && (w == 0);
        req_opts_i  = make_opts(~sb, 1, 0);
      end
      ok = !fmask[k];
      att_done_i = 1'b1;
      att_ok_i   = ok;
      @(negedge clk_i);
      att_done_i = 1'b0;
      att_ok_i   = 1'b0;
      req_valid_i = 1'b0;
      if (ok || k == n) begin
        check(done_o == 1'b1, "R10 done pulse", done_o, 1);
        check(done_ok_o == ok, ok ? "R8 success stops" : "R9 budget exhausted", done_ok_o, ok);
        check(done_attempts_o == ATT_W'(k + 1), ok ? "R8 attempt count" : "R4 R9 attempt count",
              done_attempts_o, k + 1);
        check(done_bus_o == exp_bus(sb, md, n, k), "R10 last bus", done_bus_o, exp_bus(sb, md, n, k));
        check(busy_o == 1'b0 && att_start_o == 1'b0, "R2 no stray accept", busy_o, 0);
        @(negedge clk_i);
        check(done_o == 1'b0, "R10 done one cycle", done_o, 0);
        break;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd24681));
    #1;
    check(!busy_o && !att_start_o && !done_o, "R1 reset state", busy_o + att_start_o + done_o, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!busy_o && !done_o, "R1 after release", busy_o, 0);

    // stray result while idle
    att_done_i = 1'b1; att_ok_i = 1'b1;
    @(negedge clk_i);
    att_done_i = 1'b0; att_ok_i = 1'b0;
    @(negedge clk_i);
    check(!done_o && !busy_o, "R11 idle result ignored", done_o, 0);

    run_case(1'b0, 0, 0, 8'hFF, 1, 1'b0);  // R4 single attempt
    run_case(1'b1, 0, 7, 8'hFF, 2, 1'b0);  // R4 clamp to 7 attempts
    run_case(1'b0, 1, 6, 8'hFF, 1, 1'b1);  // R6 full alternate, R2 poke
    run_case(1'b1, 2, 5, 8'hFF, 1, 1'b0);  // R7 odd n
    run_case(1'b0, 2, 4, 8'hFF, 3, 1'b0);  // R7 even n
    run_case(1'b1, 3, 3, 8'hFF, 1, 1'b0);  // R5 reserved policy
    run_case(1'b0, 1, 6, 8'b0000_0111, 2, 1'b1); // R8 success mid-way

    // result during start cycle is ignored (R11)
    @(negedge clk_i);
    req_valid_i = 1'b1; req_opts_i = make_opts(1'b1, 0, 2);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    att_done_i = 1'b1; att_ok_i = 1'b1;
    @(negedge clk_i);
    att_done_i = 1'b0; att_ok_i = 1'b0;
    check(!done_o && busy_o && !att_start_o, "R11 launch-cycle result ignored", done_o, 0);
    @(negedge clk_i);
    check(!done_o && busy_o, "R11 still waiting", busy_o, 1);
    // conclude together with a new request (R2 same-cycle)
    att_done_i = 1'b1; att_ok_i = 1'b1;
    req_valid_i = 1'b1; req_opts_i = make_opts(1'b0, 0, 0);
    @(negedge clk_i);
    att_done_i = 1'b0; att_ok_i = 1'b0;
    check(done_o && done_attempts_o == 3'd1, "R2 R10 conclude with request", done_attempts_o, 1);
    check(!busy_o && !att_start_o, "R2 request during final result ignored", busy_o, 0);
    // request during done cycle is accepted
    req_valid_i = 1'b1; req_opts_i = make_opts(1'b0, 0, 0);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check(busy_o && att_start_o && att_bus_o == 1'b0, "R2 accept on done cycle", busy_o, 1);
    @(negedge clk_i);
    att_done_i = 1'b1; att_ok_i = 1'b0;
    @(negedge clk_i);
    att_done_i = 1'b0;
    check(done_o && !done_ok_o && done_attempts_o == 3'd1, "R4 zero retries", done_attempts_o, 1);

    for (int i = 0; i < 80; i++) begin
      run_case(1'($urandom()), int'($urandom_range(0, 3)), int'($urandom_range(0, 7)),
               8'($urandom()) | (($urandom_range(0, 3) == 0) ? 8'hFF : 8'h00),
               int'($urandom_range(1, 4)), 1'($urandom()));
    end

    repeat (2) @(negedge clk_i);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule